// File: doc/BRIEF.md
# Masked Latching Input-Change Interrupt

This block watches a bank of input port bits and keeps one sticky change flag per port. A port's flag sets when its synchronized level differs from a reference snapshot. A mask register holds one enable bit per port. Any enabled flag pulls a single active-low interrupt line low, and the line stays low until the host next touches the device over the serial bus.

The serial slave reports each bus access on a one-cycle strobe. Each accepted strobe does three things: it releases the interrupt, clears every flag, and reloads the snapshot. As a result, a level that has not changed since the last access does not raise the interrupt again. If a change arrives in the same cycle as an access, the flag for that change is still recorded after the clear.

A bus-reset input from the serial side voids the transfer in progress. Any access strobe seen while bus reset is high is ignored, so the interrupt and the flags are never disturbed by a bus reset.

Top module: `port_change_irq`

## Requirements
- R1: While `rst` is high, and after it falls, `flags_o` reads 0 and `int_n` reads 1, whatever level `port_in` holds during and after reset. The mask resets to all ones, so every port is enabled.
- R2: Bit i of `flags_o` belongs to `port_in[i]`. When `port_in[i]` changes from its snapshot level, bit i of `flags_o` becomes 1 at the third rising edge after the change, and not before.
- R3: A flag stays 1 until the next accepted access, even if the port returns to its snapshot level.
- R4: A 1 in mask bit i enables port i. A write (`mask_we`, data `mask_wdata`) takes effect at the next edge. A flag on a masked port is still set but does not drive `int_n` low.
- R5: `int_n` goes low one edge after an enabled flag is present. It stays low until an accepted access, even if the mask is cleared in the meantime.
- R6: An accepted access (`access_stb` high with `bus_rst` low) clears `flags_o` and drives `int_n` high at the next edge. It also reloads the snapshot, so a level that persists afterwards does not set a flag again.
- R7: A change that reaches the synchronizer output in the same cycle as an accepted access is kept. Its flag is 1 right after the clear, and `int_n` goes low if that port is enabled.
- R8: While `bus_rst` is high, `access_stb` is ignored. Flags and `int_n` are neither cleared nor otherwise changed by the bus reset, and new changes are still recorded.
- R9: Writing a 1 to the mask bit of a port whose flag is already set drives `int_n` low one edge after the mask update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| bus_rst | input | 1 | Serial bus reset; blocks the access strobe |
| port_in | input | PORTS | Asynchronous input port levels |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | PORTS | Mask write data, 1 = port enabled |
| access_stb | input | 1 | One-cycle strobe for each serial access |
| flags_o | output | PORTS | Sticky per-port change flags |
| int_n | output | 1 | Latched interrupt, active low |

## Verification
Some rules are checked by the bound assertions on every cycle. These are the reset values, flags never clearing without an accepted access, the interrupt staying low between accesses, bus reset never clearing a flag, every interrupt fall coinciding with a set flag, and an access with a quiet input leaving the flags empty. Other behaviours only show up in the bench's timed scenarios: the exact three-edge latency, masked ports recording without interrupting, the unmask path, the same-cycle change and access, and the absence of retriggering after an access. The bench's behavioural model, compared on every clock, covers these.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

  typedef enum logic [0:0] {
    DET_WARM = 1'b0,
    DET_RUN  = 1'b1
  } det_phase_e;

  function automatic int unsigned warm_cycles(input int unsigned stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/port_sync.sv
module port_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/change_detect.sv
module change_detect
  import chg_irq_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_acc,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev_q,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] flags_nxt
);

  localparam int unsigned WARM_N = warm_cycles(STAGES);
  localparam int unsigned CNT_W  = $clog2(WARM_N + 1);

  det_phase_e       phase_q;
  logic [CNT_W-1:0] warm_cnt_q;
  logic [W-1:0]     snap_q;
  logic [W-1:0]     snap_nxt;
  logic [W-1:0]     diff_ref;
  logic [W-1:0]     diff_step;

  // Differences against the stored snapshot and against the previous level
  assign diff_ref  = lvl ^ snap_q;
  assign diff_step = lvl ^ prev_q;

  always_comb begin
    snap_nxt  = snap_q;
    flags_nxt = flags_q;
    if (phase_q == DET_WARM) begin
      // Synchronizer still filling: follow the inputs, record nothing
      snap_nxt  = lvl;
      flags_nxt = '0;
    end else if (clr_acc) begin
      // Clear first; anything moving this very cycle lands against the
      // level seen just before the access
      snap_nxt  = prev_q;
      flags_nxt = diff_step;
    end else begin
      flags_nxt = flags_q | diff_ref;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= DET_WARM;
      warm_cnt_q <= '0;
      snap_q     <= '0;
      prev_q     <= '0;
      flags_q    <= '0;
    end else begin
      snap_q  <= snap_nxt;
      prev_q  <= lvl;
      flags_q <= flags_nxt;
      if (phase_q == DET_WARM) begin
        if (warm_cnt_q == CNT_W'(WARM_N - 1)) phase_q <= DET_RUN;
        warm_cnt_q <= warm_cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_acc,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] flags_nxt,
  output logic [W-1:0] mask_q,
  output logic         int_n
);

  logic irq_q;
  logic hit;

  assign hit = |(flags_nxt & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq_q <= (clr_acc ? 1'b0 : irq_q) | hit;
    end
  end

  assign int_n = ~irq_q;

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int unsigned PORTS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic [PORTS-1:0] port_in,
  input  logic             mask_we,
  input  logic [PORTS-1:0] mask_wdata,
  input  logic             access_stb,
  output logic [PORTS-1:0] flags_o,
  output logic             int_n
);

  logic             acc_ok;
  logic [PORTS-1:0] sync_q;
  logic [PORTS-1:0] prev_q;
  logic [PORTS-1:0] flags_nxt;
  logic [PORTS-1:0] mask_q;

  // A bus reset voids the transfer, so its strobe must not clear anything
  assign acc_ok = access_stb & ~bus_rst;

  port_sync #(.W(PORTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (port_in),
    .d_sync  (sync_q)
  );

  change_detect #(.W(PORTS), .STAGES(SYNC_STAGES)) u_det (
    .clk       (clk),
    .rst       (rst),
    .clr_acc   (acc_ok),
    .lvl       (sync_q),
    .prev_q    (prev_q),
    .flags_q   (flags_o),
    .flags_nxt (flags_nxt)
  );

  irq_latch #(.W(PORTS)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .clr_acc    (acc_ok),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .flags_nxt  (flags_nxt),
    .mask_q     (mask_q),
    .int_n      (int_n)
  );

endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
  parameter int unsigned PORTS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rst,
  input logic             access_stb,
  input logic [PORTS-1:0] sync_q,
  input logic [PORTS-1:0] prev_q,
  input logic [PORTS-1:0] mask_q,
  input logic [PORTS-1:0] flags_o,
  input logic             int_n
);

  logic acc_seen;
  assign acc_seen = access_stb & ~bus_rst;

  // R1: reset leaves no flag, a released interrupt and every port enabled
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (flags_o == '0) && int_n && (mask_q == '1));

  // R3: without an accepted access no flag ever drops
  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !acc_seen |=> (($past(flags_o) & ~flags_o) == '0));

  // R5: a low interrupt stays low until an accepted access
  a_r5_int_latched: assert property (@(posedge clk) disable iff (rst)
    (!int_n && !acc_seen) |=> !int_n);

  // R2: the interrupt only falls together with a recorded flag
  a_r2_fall_has_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> (flags_o != '0));

  // R6: an accepted access with a quiet input leaves no flag
  a_r6_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc_seen && (sync_q == prev_q)) |=> (flags_o == '0));

  // R8: a bus reset never clears a flag
  a_r8_busrst_hold: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (($past(flags_o) & ~flags_o) == '0));

endmodule

bind port_change_irq port_change_irq_chk #(.PORTS(PORTS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rst    (bus_rst),
  .access_stb (access_stb),
  .sync_q     (sync_q),
  .prev_q     (prev_q),
  .mask_q     (mask_q),
  .flags_o    (flags_o),
  .int_n      (int_n)
);

// File: tb/test_port_change_irq.sv
module test_port_change_irq;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WATCHDOG = 5000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_rst = 1'b0;
  logic [N-1:0] port_in = 8'hA5;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         access_stb = 1'b0;
  logic [N-1:0] flags_o;
  logic         int_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_change_irq i_port_change_irq (
    .clk        (clk),
    .rst        (rst),
    .bus_rst    (bus_rst),
    .port_in    (port_in),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .access_stb (access_stb),
    .flags_o    (flags_o),
    .int_n      (int_n)
  );

  // Behavioural model: a queue carries the input levels through the sync delay
  logic [N-1:0] pipe[$];
  logic [N-1:0] m_last, m_ref, m_flags, m_mask;
  bit           m_irq;
  int           m_warm;

  always @(posedge clk) begin
    logic [N-1:0] lvl, nf;
    bit acc;
    if (rst) begin
      pipe = {8'h00, 8'h00};
      m_last = '0; m_ref = '0; m_flags = '0; m_mask = '1; m_irq = 0; m_warm = 0;
    end else begin
      lvl = pipe[1];
      acc = access_stb && !bus_rst;
      if (m_warm < 3) begin
        m_warm++;
        m_ref = lvl;
        nf = '0;
      end else if (acc) begin
        nf = lvl ^ m_last;
        m_ref = m_last;
      end else begin
        nf = m_flags | (lvl ^ m_ref);
      end
      m_irq = (acc ? 1'b0 : m_irq) | ((nf & m_mask) != 0);
      m_flags = nf;
      if (mask_we) m_mask = mask_wdata;
      m_last = lvl;
      void'(pipe.pop_back());
      pipe.push_front(port_in);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Continuous comparison against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model flags", 32'(flags_o), 32'(m_flags));
      chk("R5 model int_n", 32'(int_n), 32'(!m_irq));
    end
  end

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_mask(input logic [N-1:0] v);
    mask_we = 1'b1; mask_wdata = v;
    tick();
    mask_we = 1'b0;
  endtask

  initial begin
    tick(3);
    chk("R1 flags in reset", 32'(flags_o), 0);
    chk("R1 int_n in reset", 32'(int_n), 1);
    rst = 1'b0;
    tick(6);
    chk("R1 flags after reset with nonzero inputs", 32'(flags_o), 0);
    chk("R1 int_n after reset", 32'(int_n), 1);

    // R2: toggle bit 0, flag appears on the third edge
    port_in = 8'hA4;
    tick(2);
    chk("R2 flag not before third edge", 32'(flags_o), 0);
    tick();
    chk("R2 flag bit0 set", 32'(flags_o), 32'h01);
    chk("R5 int_n low", 32'(int_n), 0);

    // R3: return to old level, flag stays
    port_in = 8'hA5;
    tick(4);
    chk("R3 flag sticky after return", 32'(flags_o), 32'h01);

    // R6: access clears, no retrigger
    access_stb = 1'b1; tick(); access_stb = 1'b0;
    chk("R6 flags cleared", 32'(flags_o), 0);
    chk("R6 int_n released", 32'(int_n), 1);
    tick(4);
    chk("R6 no retrigger", 32'(flags_o), 0);

    // R4: masked port records but does not interrupt
    wr_mask(8'h0F);
    port_in = 8'h25;
    tick(3);
    chk("R4 masked flag recorded", 32'(flags_o), 32'h80);
    chk("R4 masked port no interrupt", 32'(int_n), 1);

    // R9: unmask a pending port
    wr_mask(8'hFF);
    chk("R9 one edge after mask write", 32'(int_n), 1);
    tick();
    chk("R9 int_n low after unmask", 32'(int_n), 0);

    // R5: clearing the mask does not release the interrupt
    wr_mask(8'h00);
    tick(2);
    chk("R5 int_n stays low with mask cleared", 32'(int_n), 0);
    access_stb = 1'b1; tick(); access_stb = 1'b0;
    chk("R6 access clears int_n", 32'(int_n), 1);
    wr_mask(8'hFF);
    tick(2);

    // R7: change reaches the synchronizer output in the access cycle
    port_in = 8'h24;
    tick(2);
    access_stb = 1'b1; tick(); access_stb = 1'b0;
    chk("R7 same-cycle change kept", 32'(flags_o), 32'h01);
    tick();
    chk("R7 int_n low", 32'(int_n), 0);

    // R8: bus reset blocks the access, changes still recorded
    bus_rst = 1'b1; access_stb = 1'b1;
    port_in = 8'h26;
    tick(3);
    bus_rst = 1'b0; access_stb = 1'b0;
    chk("R8 flags kept and new change recorded", 32'(flags_o), 32'h03);
    chk("R8 int_n unaffected", 32'(int_n), 0);
    tick();

    access_stb = 1'b1; tick(); access_stb = 1'b0;
    chk("R6 final clear", 32'(flags_o), 0);
    tick(2);
    summary();
  end

endmodule